// File: doc/BRIEF.md
# Branch Target Buffer Predictor

The block is a direct-mapped branch target buffer that predicts the next fetch address. The fetch stage presents its current address and instruction length every cycle. If a valid entry's tag matches, the block reports a hit together with the stored outcome and destination. The predicted next fetch address is either the stored destination, when the entry says taken, or the sequential address.

Branches resolve late, in writeback. The resolving branch brings back its address, its length, its actual outcome and target, and the prediction it was fetched with. Every accepted resolution writes its entry with the actual outcome, target and tag. This both allocates new entries and refreshes old ones. When the carried prediction was wrong, the block raises a one-cycle redirect with the correct address. It also holds a squash signal for a fixed three-cycle recovery window that discards the younger instructions.

Top module: `branch_target_buffer`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses, and both the redirect strobe and the squash signal are low.
- R2: The entry index is fetch address bits [9:2] and the tag is bits [31:10]. A lookup hits when that entry is valid and its tag matches. A hit reports the stored taken flag and stored target in the same cycle.
- R3: The predicted next fetch address is the stored target on a hit whose taken flag is 1. It is fetch address plus fetch length on a miss or on a not-taken hit.
- R4: An accepted resolution writes the entry at its index with its own tag, replacing any other branch that shares that index, so the older branch then misses.
- R5: When a lookup and an accepted resolution use the same entry in one cycle, the lookup returns the contents from before the write.
- R6: A resolution is a mispredict if the actual outcome differs from the carried predicted outcome, or if it is taken with a target that differs from the carried predicted target. A mispredict raises the redirect strobe for exactly the one cycle after the resolution; a correct prediction raises nothing.
- R7: The redirect address is the actual target for a taken branch, and branch address plus branch length for a not-taken branch.
- R8: After a mispredict the squash signal is high for exactly the three cycles after the resolution cycle.
- R9: A resolution presented while squash is high belongs to a discarded instruction and is ignored: it writes no entry and raises no redirect.
- R10: Not-taken resolutions are stored as well, so a later lookup hits with taken flag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fetchAddr | input | 32 | Address being fetched |
| fetchLen | input | 4 | Length in bytes of the fetched instruction |
| predHit | output | 1 | Valid entry with matching tag |
| predTaken | output | 1 | Stored outcome of the hit entry |
| predTarget | output | 32 | Stored destination of the hit entry |
| nextFetch | output | 32 | Predicted next fetch address |
| updValid | input | 1 | A branch resolves this cycle |
| updAddr | input | 32 | Address of the resolving branch |
| updLen | input | 4 | Length of the resolving branch |
| updTaken | input | 1 | Actual outcome |
| updTarget | input | 32 | Actual destination |
| updPredTaken | input | 1 | Outcome predicted at fetch |
| updPredTarget | input | 32 | Target predicted at fetch |
| redirectValid | output | 1 | One-cycle mispredict strobe |
| redirectAddr | output | 32 | Correct-path fetch address |
| squash | output | 1 | Recovery window that discards younger instructions |

## Verification
A corrupted tag, valid bit or stored target shows up at the lookup port in the same cycle the entry is next fetched. The symptom is a wrong hit flag, a wrong taken flag or a wrong next-fetch address. A wrong mispredict decision or a wrong penalty counter shows up one cycle after resolution, as a missing or extra redirect strobe, a wrong redirect address, or a squash window of the wrong length. An update leaking through the squash window is caught on a later lookup of that address and by an unexpected redirect. Aliasing branches and same-cycle read/write are driven on purpose so that index and tag slicing and read ordering are observed.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef struct packed {
    logic wrEntry;
    logic loadRedirect;
  } btbStrobe_t;
endpackage

// File: rtl/btb_datapath.sv
module btb_datapath
  import btb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 256,
  parameter int OFF_W   = 2,
  parameter int LEN_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  btbStrobe_t        strobe,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [LEN_W-1:0]  fetchLen,
  output logic              predHit,
  output logic              predTaken,
  output logic [ADDR_W-1:0] predTarget,
  output logic [ADDR_W-1:0] nextFetch,
  input  logic [ADDR_W-1:0] updAddr,
  input  logic [LEN_W-1:0]  updLen,
  input  logic              updTaken,
  input  logic [ADDR_W-1:0] updTarget,
  input  logic              updPredTaken,
  input  logic [ADDR_W-1:0] updPredTarget,
  output logic              mispredict,
  output logic [ADDR_W-1:0] redirectAddr
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [ENTRIES-1:0] entValid;
  logic [TAG_W-1:0]   entTag    [ENTRIES];
  logic [ADDR_W-1:0]  entTarget [ENTRIES];
  logic               entTaken  [ENTRIES];

  logic [IDX_W-1:0] lookIdx, updIdx;
  logic [TAG_W-1:0] lookTag, updTag;

  assign lookIdx = fetchAddr[OFF_W +: IDX_W];
  assign lookTag = fetchAddr[ADDR_W-1 -: TAG_W];
  assign updIdx  = updAddr[OFF_W +: IDX_W];
  assign updTag  = updAddr[ADDR_W-1 -: TAG_W];

  // Lookup reads the array combinationally, so a write at this edge is not yet visible.
  always_comb begin
    predHit    = entValid[lookIdx] && (entTag[lookIdx] == lookTag);
    predTaken  = predHit && entTaken[lookIdx];
    predTarget = predHit ? entTarget[lookIdx] : '0;
    nextFetch  = predTaken ? entTarget[lookIdx] : fetchAddr + ADDR_W'(fetchLen);
  end

  always_comb begin
    mispredict = (updTaken != updPredTaken) ||
                 (updTaken && (updTarget != updPredTarget));
  end

  // Per-entry storage; only valid bits are reset.
  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        entValid[e] <= 1'b0;
      end else if (strobe.wrEntry && (updIdx == IDX_W'(e))) begin
        entValid[e] <= 1'b1;
      end
    end
    always_ff @(posedge clk) begin
      if (strobe.wrEntry && (updIdx == IDX_W'(e))) begin
        entTag[e]    <= updTag;
        entTarget[e] <= updTarget;
        entTaken[e]  <= updTaken;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirectAddr <= '0;
    end else if (strobe.loadRedirect) begin
      redirectAddr <= updTaken ? updTarget : updAddr + ADDR_W'(updLen);
    end
  end
endmodule

// File: rtl/btb_control.sv
module btb_control
  import btb_pkg::*;
#(
  parameter int PENALTY = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       updValid,
  input  logic       mispredict,
  output btbStrobe_t strobe,
  output logic       redirectValid,
  output logic       squash
);
  localparam int CNT_W = $clog2(PENALTY + 1);

  logic [CNT_W-1:0] penaltyCnt;
  logic             accept;

  assign accept = updValid && (penaltyCnt == '0);
  assign squash = (penaltyCnt != '0);

  always_comb begin
    strobe.wrEntry      = accept;
    strobe.loadRedirect = accept && mispredict;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      penaltyCnt    <= '0;
      redirectValid <= 1'b0;
    end else begin
      redirectValid <= strobe.loadRedirect;
      if (strobe.loadRedirect) begin
        penaltyCnt <= CNT_W'(PENALTY);
      end else if (penaltyCnt != '0) begin
        penaltyCnt <= penaltyCnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/branch_target_buffer.sv
module branch_target_buffer
  import btb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 256,
  parameter int OFF_W   = 2,
  parameter int LEN_W   = 4,
  parameter int PENALTY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [LEN_W-1:0]  fetchLen,
  output logic              predHit,
  output logic              predTaken,
  output logic [ADDR_W-1:0] predTarget,
  output logic [ADDR_W-1:0] nextFetch,
  input  logic              updValid,
  input  logic [ADDR_W-1:0] updAddr,
  input  logic [LEN_W-1:0]  updLen,
  input  logic              updTaken,
  input  logic [ADDR_W-1:0] updTarget,
  input  logic              updPredTaken,
  input  logic [ADDR_W-1:0] updPredTarget,
  output logic              redirectValid,
  output logic [ADDR_W-1:0] redirectAddr,
  output logic              squash
);
  btbStrobe_t strobe;
  logic       mispredict;

  btb_control #(.PENALTY(PENALTY)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .updValid(updValid), .mispredict(mispredict),
    .strobe(strobe), .redirectValid(redirectValid), .squash(squash)
  );

  btb_datapath #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .OFF_W(OFF_W), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .fetchAddr(fetchAddr), .fetchLen(fetchLen),
    .predHit(predHit), .predTaken(predTaken), .predTarget(predTarget), .nextFetch(nextFetch),
    .updAddr(updAddr), .updLen(updLen), .updTaken(updTaken), .updTarget(updTarget),
    .updPredTaken(updPredTaken), .updPredTarget(updPredTarget),
    .mispredict(mispredict), .redirectAddr(redirectAddr)
  );
endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 4,
  parameter int PENALTY = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic [LEN_W-1:0]  fetchLen,
  input logic              predHit,
  input logic              predTaken,
  input logic [ADDR_W-1:0] predTarget,
  input logic [ADDR_W-1:0] nextFetch,
  input logic              updValid,
  input logic              updTaken,
  input logic [ADDR_W-1:0] updTarget,
  input logic              updPredTaken,
  input logic [ADDR_W-1:0] updPredTarget,
  input logic              redirectValid,
  input logic              squash
);
  int runLen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) runLen <= 0;
    else if (squash) runLen <= runLen + 1;
    else runLen <= 0;
  end

  AST_FALLTHRU_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    !predTaken |-> nextFetch == fetchAddr + ADDR_W'(fetchLen)); // R3
  AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    predTaken |-> (predHit && nextFetch == predTarget)); // R2
  AST_MISPRED_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (updValid && !squash && ((updTaken != updPredTaken) || (updTaken && updTarget != updPredTarget)))
      |=> redirectValid); // R6
  AST_CORRECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (updValid && updTaken == updPredTaken && (!updTaken || updTarget == updPredTarget))
      |=> !redirectValid); // R6
  AST_REDIRECT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    redirectValid |=> !redirectValid); // R6
  AST_SQUASH_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(squash) |-> redirectValid); // R8
  AST_SQUASH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    squash |-> runLen < PENALTY); // R8
  AST_SQUASH_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(squash) |-> runLen == PENALTY); // R8
  AST_SQUASH_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (updValid && squash) |=> !redirectValid); // R9
endmodule

bind branch_target_buffer btb_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PENALTY(PENALTY)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetchAddr(fetchAddr), .fetchLen(fetchLen),
  .predHit(predHit), .predTaken(predTaken), .predTarget(predTarget), .nextFetch(nextFetch),
  .updValid(updValid), .updTaken(updTaken), .updTarget(updTarget),
  .updPredTaken(updPredTaken), .updPredTarget(updPredTarget),
  .redirectValid(redirectValid), .squash(squash)
);

// File: tb/sim_branch_target_buffer.sv
module sim_branch_target_buffer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetchAddr = '0;
  logic [3:0]  fetchLen = 4'd4;
  logic        predHit, predTaken, redirectValid, squash;
  logic [31:0] predTarget, nextFetch, redirectAddr;
  logic        updValid = 1'b0, updTaken = 1'b0, updPredTaken = 1'b0;
  logic [31:0] updAddr = '0, updTarget = '0, updPredTarget = '0;
  logic [3:0]  updLen = 4'd4;

  always #10 clk = ~clk;

  branch_target_buffer u0 (
    .clk(clk), .rst_n(rst_n), .fetchAddr(fetchAddr), .fetchLen(fetchLen),
    .predHit(predHit), .predTaken(predTaken), .predTarget(predTarget), .nextFetch(nextFetch),
    .updValid(updValid), .updAddr(updAddr), .updLen(updLen), .updTaken(updTaken),
    .updTarget(updTarget), .updPredTaken(updPredTaken), .updPredTarget(updPredTarget),
    .redirectValid(redirectValid), .redirectAddr(redirectAddr), .squash(squash)
  );

  typedef struct {
    int          cyc;
    int          sel;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t q[$];

  int checks = 0, fails = 0, cycCnt = 0;
  always @(posedge clk) cycCnt <= cycCnt + 1;

  // Reference model
  bit          mValid [256];
  logic [21:0] mTag   [256];
  logic [31:0] mTgt   [256];
  bit          mTaken [256];
  int          sqLeft = 0;
  bit          prevRedir = 0;

  function automatic logic [31:0] portVal(int sel);
    case (sel)
      0: return {31'd0, predHit};
      1: return {31'd0, predTaken};
      2: return predTarget;
      3: return nextFetch;
      4: return {31'd0, redirectValid};
      5: return redirectAddr;
      default: return {31'd0, squash};
    endcase
  endfunction

  task automatic expect_at(int sel, logic [31:0] v, int dly, string req);
    item_t it;
    it.cyc = cycCnt + dly; it.sel = sel; it.exp = v; it.req = req;
    q.push_back(it);
  endtask

  // Monitor: compares queued expectations away from the clock edge.
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].cyc == cycCnt) begin
        checks++;
        if (portVal(q[i].sel) !== q[i].exp) begin
          fails++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", q[i].req, q[i].sel,
                   portVal(q[i].sel), q[i].exp);
        end
        q.delete(i);
      end
    end
  end

  // Driver: one cycle of stimulus plus expectations from the model.
  task automatic step(input bit doLook, input logic [31:0] la, input logic [3:0] ll,
                      input bit doUpd, input logic [31:0] ua, input logic [3:0] ul,
                      input bit ut, input logic [31:0] utg,
                      input bit upt, input logic [31:0] uptg, input string req);
    int  li, ui, newLeft;
    bit  hit, accept, mis;
    fetchAddr = la; fetchLen = ll;
    updValid = doUpd; updAddr = ua; updLen = ul; updTaken = ut;
    updTarget = utg; updPredTaken = upt; updPredTarget = uptg;
    expect_at(6, {31'd0, sqLeft != 0}, 0, {req, " R8 squash"});
    expect_at(4, {31'd0, prevRedir}, 0, {req, " R6 redirect"});
    if (doLook) begin
      li  = int'(la[9:2]);
      hit = mValid[li] && mTag[li] == la[31:10];
      expect_at(0, {31'd0, hit}, 0, {req, " R2 hit"});
      if (hit) begin
        expect_at(1, {31'd0, mTaken[li]}, 0, {req, " R2 taken"});
        expect_at(2, mTgt[li], 0, {req, " R2 target"});
      end
      expect_at(3, (hit && mTaken[li]) ? mTgt[li] : la + 32'(ll), 0, {req, " R3 next"});
    end
    accept = doUpd && sqLeft == 0;
    mis = accept && ((ut != upt) || (ut && utg != uptg));
    if (mis) expect_at(5, ut ? utg : ua + 32'(ul), 1, {req, " R7 redirectAddr"});
    newLeft = (sqLeft > 0) ? sqLeft - 1 : 0;
    if (mis) newLeft = 3;
    @(posedge clk); #1;
    if (accept) begin
      ui = int'(ua[9:2]);
      mValid[ui] = 1; mTag[ui] = ua[31:10]; mTgt[ui] = utg; mTaken[ui] = ut;
    end
    sqLeft = newLeft;
    prevRedir = mis;
  endtask

  task automatic look(input logic [31:0] a, input logic [3:0] l, input string req);
    step(1, a, l, 0, '0, 4'd0, 0, '0, 0, '0, req);
  endtask

  task automatic upd(input logic [31:0] a, input logic [3:0] l, input bit t, input logic [31:0] tg,
                     input bit pt, input logic [31:0] ptg, input string req);
    step(0, '0, 4'd4, 1, a, l, t, tg, pt, ptg, req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1: empty after reset
    look(32'h0000_0100, 4'd4, "R1 reset miss");
    look(32'h0000_0204, 4'd2, "R1 reset miss odd len");
    // R6 R7 R8: taken branch predicted not-taken
    upd(32'h0000_0100, 4'd4, 1, 32'h0000_2000, 0, '0, "R6 mispredict taken");
    // R9: update inside the squash window is dropped
    step(1, 32'h0000_0100, 4'd4, 1, 32'h0000_0300, 4'd4, 1, 32'h0000_7000, 0, '0, "R9 drop during squash");
    look(32'h0000_0100, 4'd4, "R2 hit taken");
    look(32'h0000_0300, 4'd4, "R9 dropped entry misses");
    look(32'h0000_0300, 4'd4, "R9 after squash");
    // R6: correct prediction, no redirect
    upd(32'h0000_0100, 4'd4, 1, 32'h0000_2000, 1, 32'h0000_2000, "R6 correct");
    look(32'h0000_0100, 4'd4, "R2 still hit");
    // R5 R7 R10: same-cycle lookup and not-taken resolution
    step(1, 32'h0000_0100, 4'd3, 1, 32'h0000_0100, 4'd3, 0, 32'h0000_2000, 1, 32'h0000_2000, "R5 old contents");
    repeat (3) look(32'h0000_0100, 4'd3, "R10 not-taken hit");
    // R4: aliasing branch replaces the entry
    upd(32'h0004_0100, 4'd4, 1, 32'h0000_5000, 0, '0, "R4 alias alloc");
    repeat (3) look(32'h0000_0100, 4'd4, "R4 evicted");
    look(32'h0004_0100, 4'd4, "R4 alias hit");
    // R6 R7: taken with wrong predicted target
    upd(32'h0004_0100, 4'd4, 1, 32'h0000_6000, 1, 32'h0000_5000, "R6 target mismatch");
    look(32'h0004_0100, 4'd4, "R8 squash window");
    look(32'h0004_0100, 4'd4, "R8 squash window");
    look(32'h0004_0100, 4'd4, "R8 squash window");
    // back-to-back mispredict right after the window
    upd(32'h0000_0ffc, 4'd4, 0, 32'h0000_9000, 1, 32'h0000_9000, "R7 not-taken redirect");
    repeat (3) look(32'h0000_0ffc, 4'd4, "R10 stored not-taken");
    look(32'h0004_0100, 4'd4, "R2 updated target");
    repeat (3) look(32'h0000_0000, 4'd4, "R1 idle");
    #5;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule